// File: doc/BRIEF.md
# Register-Mapped FIFO with Fill-Level Interrupt

This block is a synchronous first-in first-out store of 32-bit words that software reaches only through a small register-mapped slave port. A write to the data register adds one word to the tail of the queue. A read of the data register removes the oldest word and returns it. A threshold register and read-only status registers sit in the same address map. The status registers report whether the queue is empty or full and how many words it holds.

The port carries one request at a time. A request has a valid/ready pair, a byte address, write data and byte strobes. If any strobe bit is set the request is a write, and if every strobe bit is clear it is a read. Read data returns on a separate response pulse. A level-sensitive interrupt stays high while the number of stored words is at or above the programmed threshold. The threshold resets to zero, so the interrupt is high out of reset. Firmware normally programs the threshold first and then services the interrupt by draining the queue.

Register map. Reads decode the word address, which is byte address bits [ADDR_W-1:2]:

| Byte address | Register | Access |
|---|---|---|
| 0x0 | Queue data | write pushes, read pops |
| 0x4 | Threshold, 32 bits | write-only |
| 0x8 | Status word: bit 0 is empty, bit 8 is full | read-only |
| 0xC | Fill level | read-only |

Top module: `mmfifo_irq`

## Requirements
- R1: After reset the status word (byte 0x8) reads 1, meaning bit 0 empty=1 and bit 8 full=0. The level (0xC) reads 0 and the threshold is 0.
- R2: `req_ready` rises in the cycle after the block sees `req_valid` with `req_ready` low, and it stays high for exactly one cycle. The request is accepted in the cycle in which `req_valid` and `req_ready` are both high.
- R3: After an accepted read, `rsp_valid` is high for exactly one cycle, in the cycle that follows acceptance, and `rsp_data` carries the read value in that cycle. An accepted write produces no response.
- R4: A write whose target byte is 0x0 pushes all 32 bits of `req_wdata`. A read of word 0 pops the words in the order they were written.
- R5: The target byte of a write is the word base address plus the index of the lowest set strobe bit. A write whose target is neither 0x0 nor 0x4 changes nothing. For example, strobe 4'b0010 at address 0x0 targets byte 0x1 and does not push.
- R6: The level register reports the number of stored words. Status bit 8 is 1 exactly when the level equals DEPTH, and status bit 0 is 1 exactly when the level is 0.
- R7: A push while the queue is full is ignored: the level stays at DEPTH and the stored words are unchanged.
- R8: A pop while the queue is empty returns 0 and leaves the level at 0.
- R9: `irq` is high exactly when level >= threshold. A write whose target is 0x4 loads the threshold from `req_wdata`.
- R10: Reads of the threshold address and of unmapped words (word index 4 and above) return 0.
- R11: The level changes by at most one per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until accepted |
| req_ready | output | 1 | One-cycle acceptance pulse |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte strobes; all zero means read |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 32 | Read response data |
| irq | output | 1 | High while level >= threshold |

## Verification
The assertions assume that the requester holds `req_valid` and its request fields steady until `req_ready` is seen. They also assume that it drops `req_valid` in the cycle after acceptance, so that one request is never taken twice. The bench's access task drives every request this way. It raises valid at a falling edge, waits for the ready pulse, and then lowers valid at the next falling edge. It also leaves an idle cycle before the next request, so a read response always completes first. Random operations mix pushes, pops, threshold writes, status reads and writes with offset strobes. These are checked against a queue model in the bench, and directed sequences drive the queue to full and to empty.

// File: rtl/mmfifo_pkg.sv
package mmfifo_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned STRB_W  = WORD_W / 8;
   // byte targets that accept writes
   localparam int unsigned TGT_DATA   = 0;
   localparam int unsigned TGT_THRESH = 4;
   // word indices that return data on reads
   localparam int unsigned WIDX_DATA   = 0;
   localparam int unsigned WIDX_STATUS = 2;
   localparam int unsigned WIDX_LEVEL  = 3;
   // bit positions in the status word
   localparam int unsigned BIT_EMPTY = 0;
   localparam int unsigned BIT_FULL  = 8;

   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_RSP  = 1'b1
   } hs_state_t;
endpackage

// File: rtl/mmfifo_store.sv
module mmfifo_store #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] level,
   output logic             empty,
   output logic             full
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mmfifo_store: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_inc, rd_ptr_inc;
   logic             push_ok, pop_ok;

   assign empty   = (level == '0);
   assign full    = (level == CNT_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_ptr_inc = wr_ptr + 1'b1;
         assign rd_ptr_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_ptr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr_inc;
         if (pop_ok)  rd_ptr <= rd_ptr_inc;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/mmfifo_hs.sv
module mmfifo_hs
   import mmfifo_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic is_wr,
   output logic ready,
   output logic accept
);
   hs_state_t state, state_n;
   logic      ready_n;

   assign accept = valid && ready;

   always_comb begin
      state_n = state;
      ready_n = 1'b0;
      case (state)
         HS_IDLE: begin
            if (valid && !ready) ready_n = 1'b1;
            if (accept && !is_wr) state_n = HS_RSP;
         end
         HS_RSP: state_n = HS_IDLE;
         default: state_n = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= HS_IDLE;
         ready <= 1'b0;
      end else begin
         state <= state_n;
         ready <= ready_n;
      end
   end
endmodule

// File: rtl/mmfifo_decode.sv
module mmfifo_decode
   import mmfifo_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              accept,
   input  logic [WORD_W-1:0] head,
   input  logic              empty,
   input  logic              full,
   input  logic [CNT_W-1:0]  level,
   output logic              push,
   output logic              pop,
   output logic              thr_we,
   output logic [WORD_W-1:0] rd_word
);
   localparam int unsigned LSB_W = $clog2(STRB_W);

   logic              is_wr;
   logic [ADDR_W-1:0] ofs, tgt, base;
   logic [ADDR_W-LSB_W-1:0] widx;

   assign is_wr = |wstrb;
   assign base  = addr & {{(ADDR_W-LSB_W){1'b1}}, {LSB_W{1'b0}}};
   assign widx  = addr[ADDR_W-1:LSB_W];

   always_comb begin
      ofs = '0;
      for (int i = STRB_W - 1; i >= 0; i--) begin
         if (wstrb[i]) ofs = ADDR_W'(i);
      end
   end

   assign tgt    = base + ofs;
   assign push   = accept && is_wr && (tgt == ADDR_W'(TGT_DATA));
   assign thr_we = accept && is_wr && (tgt == ADDR_W'(TGT_THRESH));
   assign pop    = accept && !is_wr && (widx == '0);

   always_comb begin
      rd_word = '0;
      case (widx)
         (ADDR_W-LSB_W)'(WIDX_DATA):   rd_word = empty ? '0 : head;
         (ADDR_W-LSB_W)'(WIDX_STATUS): begin
            rd_word[BIT_EMPTY] = empty;
            rd_word[BIT_FULL]  = full;
         end
         (ADDR_W-LSB_W)'(WIDX_LEVEL):  rd_word = WORD_W'(level);
         default:                      rd_word = '0;
      endcase
   end
endmodule

// File: rtl/mmfifo_irq.sv
module mmfifo_irq
   import mmfifo_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [STRB_W-1:0] req_wstrb,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_data,
   output logic              irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("mmfifo_irq: ADDR_W must cover byte 0xC");
      end
      if (CNT_W > WORD_W) begin : g_bad_cnt
         $error("mmfifo_irq: DEPTH too large for level register");
      end
   endgenerate

   logic              accept, is_wr, push, pop, thr_we;
   logic              fifo_empty, fifo_full;
   logic [CNT_W-1:0]  lvl;
   logic [WORD_W-1:0] head, rd_word, thresh;

   assign is_wr = |req_wstrb;

   mmfifo_hs u_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (req_valid),
      .is_wr  (is_wr),
      .ready  (req_ready),
      .accept (accept)
   );

   mmfifo_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
      .addr    (req_addr),
      .wstrb   (req_wstrb),
      .accept  (accept),
      .head    (head),
      .empty   (fifo_empty),
      .full    (fifo_full),
      .level   (lvl),
      .push    (push),
      .pop     (pop),
      .thr_we  (thr_we),
      .rd_word (rd_word)
   );

   mmfifo_store #(.W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .din   (req_wdata),
      .head  (head),
      .level (lvl),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thresh    <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         if (thr_we) thresh <= req_wdata;
         rsp_valid <= accept && !is_wr;
         if (accept && !is_wr) rsp_data <= rd_word;
      end
   end

   assign irq = (WORD_W'(lvl) >= thresh);
endmodule

// File: rtl/mmfifo_chk.sv
module mmfifo_chk #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [3:0]        req_wstrb,
   input logic              rsp_valid,
   input logic [CNT_W-1:0]  lvl,
   input logic              fifo_empty,
   input logic              fifo_full
);
   logic acc_rd, acc_push;
   assign acc_rd   = req_valid && req_ready && (req_wstrb == 4'b0000);
   assign acc_push = req_valid && req_ready && req_wstrb[0] && (req_addr[ADDR_W-1:2] == '0);

   p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> rsp_valid);

   p_no_rsp_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_wstrb != 4'b0000)) |=> !rsp_valid);

   p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= CNT_W'(DEPTH));

   p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_push && fifo_full) |=> (lvl == CNT_W'(DEPTH)));

   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && (req_addr[ADDR_W-1:2] == '0) && fifo_empty) |=> (lvl == '0));

   p_level_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lvl == $past(lvl)) || (lvl == $past(lvl) + 1'b1) || (lvl + 1'b1 == $past(lvl))));
endmodule

bind mmfifo_irq mmfifo_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .req_wstrb  (req_wstrb),
   .rsp_valid  (rsp_valid),
   .lvl        (lvl),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full)
);

// File: tb/sim_mmfifo_irq.sv
module sim_mmfifo_irq;
   localparam int CLK_P = 10;
   localparam int DEPTH = 16;
   localparam int AW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [3:0]    req_wstrb = '0;
   logic          req_ready, rsp_valid, irq;
   logic [31:0]   rsp_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] mq[$];
   logic [31:0] mthr = 0;

   always #(CLK_P/2) clk = ~clk;

   mmfifo_irq #(.DEPTH(DEPTH), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic int tgt_of(input logic [AW-1:0] a, input logic [3:0] s);
      int o = 0;
      for (int i = 3; i >= 0; i--) if (s[i]) o = i;
      return int'(a & 5'b11100) + o;
   endfunction

   function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
      int w = int'(a) / 4;
      if (w == 0) return (mq.size() == 0) ? 32'h0 : mq[0];
      if (w == 2) return {23'b0, (mq.size() == DEPTH), 7'b0, (mq.size() == 0)};
      if (w == 3) return 32'(mq.size());
      return 32'h0;
   endfunction

   function automatic logic exp_irq();
      return (32'(mq.size()) >= mthr);
   endfunction

   task automatic acc(input logic [AW-1:0] a, input logic [31:0] wd,
                      input logic [3:0] st, output logic [31:0] rd);
      int waits = 0;
      logic [31:0] exp = exp_read(a);
      int prev = mq.size();
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_wdata = wd; req_wstrb = st;
      @(negedge clk);
      while (!req_ready && waits < 50) begin waits++; @(negedge clk); end
      chk("R2 ready one cycle after valid", 32'(waits), 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 ready is a single pulse", {31'b0, req_ready}, 0);
      rd = rsp_data;
      if (st == 4'b0000) begin
         chk("R3 response one cycle after read", {31'b0, rsp_valid}, 1);
         chk("R4 R6 R8 R10 read data", rsp_data, exp);
         if (int'(a) / 4 == 0 && mq.size() > 0) void'(mq.pop_front());
      end else begin
         chk("R3 no response to write", {31'b0, rsp_valid}, 0);
         if (tgt_of(a, st) == 0 && mq.size() < DEPTH) mq.push_back(wd);
         if (tgt_of(a, st) == 4) mthr = wd;
      end
      chk("R11 level step", 32'((mq.size() - prev) * (mq.size() - prev) <= 1), 1);
      chk("R9 irq level vs threshold", {31'b0, irq}, {31'b0, exp_irq()});
      @(negedge clk);
      chk("R3 response lasts one cycle", {31'b0, rsp_valid}, 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 irq high with reset threshold 0", {31'b0, irq}, 1);
      acc(5'h08, 0, 4'b0000, rd);
      chk("R1 status after reset", rd, 32'h1);
      acc(5'h0C, 0, 4'b0000, rd);
      chk("R1 level after reset", rd, 0);

      // threshold 3, irq goes high at third push
      acc(5'h04, 3, 4'b1111, rd);
      chk("R9 irq low below threshold", {31'b0, irq}, 0);
      acc(5'h00, 32'hA1, 4'b1111, rd);
      acc(5'h00, 32'hB2, 4'b0001, rd);
      chk("R9 irq low at level 2", {31'b0, irq}, 0);
      acc(5'h00, 32'hC3, 4'b1111, rd);
      chk("R9 irq high at level 3", {31'b0, irq}, 1);
      // offset strobes: target 0x1 and 0x7, neither has effect
      acc(5'h00, 32'hDEAD, 4'b0010, rd);
      acc(5'h04, 32'h0, 4'b1000, rd);
      acc(5'h0C, 0, 4'b0000, rd);
      chk("R5 offset-strobe writes ignored", rd, 3);
      acc(5'h04, 0, 4'b0000, rd);
      chk("R10 threshold reads as zero", rd, 0);
      acc(5'h14, 0, 4'b0000, rd);
      chk("R10 unmapped read zero", rd, 0);
      acc(5'h00, 0, 4'b0000, rd);
      chk("R4 first word out", rd, 32'hA1);
      acc(5'h00, 0, 4'b0000, rd);
      chk("R4 second word out", rd, 32'hB2);

      // fill to full and push once more
      for (int i = 0; i < DEPTH; i++) acc(5'h00, 32'h100 + i, 4'b1111, rd);
      acc(5'h0C, 0, 4'b0000, rd);
      chk("R7 level stays at DEPTH", rd, DEPTH);
      acc(5'h08, 0, 4'b0000, rd);
      chk("R6 full flag set", rd, 32'h100);
      acc(5'h00, 0, 4'b0000, rd);
      chk("R7 oldest word kept after overflow", rd, 32'hC3);
      // drain and pop once more
      while (mq.size() > 0) acc(5'h00, 0, 4'b0000, rd);
      acc(5'h00, 0, 4'b0000, rd);
      chk("R8 pop on empty returns zero", rd, 0);
      acc(5'h0C, 0, 4'b0000, rd);
      chk("R8 level stays zero", rd, 0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int r = int'($urandom % 10);
         logic [3:0] s = 4'($urandom % 15) + 4'd1;
         if (r < 4)      acc(5'h00, $urandom, (r == 0) ? s : 4'b1111, rd);
         else if (r < 7) acc(5'h00, 0, 4'b0000, rd);
         else if (r == 7) acc(5'h04, $urandom % (DEPTH + 3), 4'b0001, rd);
         else if (r == 8) acc((n % 2) ? 5'h08 : 5'h0C, 0, 4'b0000, rd);
         else            acc(5'(($urandom % 8) * 4), $urandom, ($urandom % 2) ? 4'b0000 : s, rd);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule